// File: doc/BRIEF.md
# Paged RAM window address translator

This block maps a 16-bit local CPU address onto a 23-bit global address. A single 4 KByte slice of the local map, 0x1000 to 0x1FFF, is a movable window: an 8-bit page index register picks which 4 KByte page of global RAM the window shows. Two 16 KByte slices of the local map are tied to constant flash pages. Every other local address passes through unchanged into the lowest part of the global map.

Software sets the page index over a small write port and can read it back at any time. The address translation is purely combinational from the local address, the ROM-high-map control and the current index value. A new index therefore applies to the first access after the clock edge that stores it. A region code tells the memory fabric which kind of target was hit. A separate flag marks writes that go through the window while the index is 0x00, because page 0 occupies the same global addresses as the register space.

Top module: `ram_window_xlat`

## Requirements
- R1: On reset the page index reads back as 0xFD.
- R2: When cfg_we is high at a rising clock edge, cfg_wdata is stored as the page index and is visible on cfg_rdata and in the translation after that edge. Before that edge the old value stays in effect. When cfg_we is low, the index holds its value.
- R3: A local address from 0x1000 to 0x1FFF gives region code 2'b01. The global address then has bits 19:12 equal to the page index and bits 11:0 equal to local bits 11:0.
- R4: On a RAM window hit, global address bits 22:20 are zero.
- R5: reg_alias_wr is 1 exactly when the address hits the RAM window, the page index is 0x00 and loc_wr is 1. In all other cases it is 0.
- R6: When rom_hi_map is 0, a local address from 0x4000 to 0x7FFF gives region code 2'b10 and global address 0x400000 + 0xFD*0x4000 + (local mod 0x4000).
- R7: When rom_hi_map is 1, a local address from 0x4000 to 0x7FFF is unpaged. It gives region code 2'b00 and a global address equal to the local address.
- R8: A local address from 0xC000 to 0xFFFF gives region code 2'b10 and global address 0x400000 + 0xFF*0x4000 + (local mod 0x4000), whatever the value of rom_hi_map.
- R9: Any other local address gives region code 2'b00 and a global address equal to the local address, with bits 22:16 zero.
- R10: glb_addr, region and reg_alias_wr follow a change of loc_addr, loc_wr or rom_hi_map within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the page index |
| cfg_wdata | input | 8 | New page index value |
| cfg_rdata | output | 8 | Current page index |
| rom_hi_map | input | 1 | 0: low flash window is active; 1: the 0x4000 to 0x7FFF slice is unpaged |
| loc_addr | input | 16 | Local CPU address |
| loc_wr | input | 1 | The current access is a write |
| glb_addr | output | 23 | Translated global address |
| region | output | 2 | 00 unpaged, 01 paged RAM, 10 fixed flash |
| reg_alias_wr | output | 1 | Write through the window onto the register space (index 0x00) |

## Verification
The checker assumes that loc_addr, loc_wr, rom_hi_map, cfg_we and cfg_wdata are known, with no X or Z bits, at every sampling edge after reset. It also assumes that the combinational outputs have settled by then. The bench drives every input to a defined value before it releases reset. It changes inputs only a few time units after a rising edge, so each value is stable across the next edge. The address sweeps cover every local address for one index and a strided set of addresses for other indexes and for both settings of the map control.

// File: rtl/ram_window_xlat_pkg.sv
package ram_window_xlat_pkg;

  typedef enum logic [1:0] {
    RGN_PLAIN = 2'b00,
    RGN_RAM   = 2'b01,
    RGN_FLASH = 2'b10
  } region_e;

endpackage

// File: rtl/xlat_page_reg.sv
module xlat_page_reg #(
  parameter int            PG_W    = 8,
  parameter logic [PG_W-1:0] RST_VAL = 8'hFD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PG_W-1:0] wdata,
  output logic [PG_W-1:0] page_q
);

  logic [PG_W-1:0] page_d;

  // next-state: the clock enable is the write strobe
  always_comb begin
    page_d = page_q;
    if (wr_en) begin
      page_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= RST_VAL;
    end else begin
      page_q <= page_d;
    end
  end

endmodule

// File: rtl/xlat_window_decode.sv
module xlat_window_decode #(
  parameter int              LA_W          = 16,
  parameter int              RAM_WIN_AW    = 12,
  parameter int              FLASH_WIN_AW  = 14,
  parameter logic [LA_W-1:0] RAM_WIN_BASE  = 16'h1000,
  parameter logic [LA_W-1:0] FLASH_LO_BASE = 16'h4000,
  parameter logic [LA_W-1:0] FLASH_HI_BASE = 16'hC000,
  parameter bit              LO_FLASH_EN   = 1'b1,
  localparam int             RTAG_W        = LA_W - RAM_WIN_AW,
  localparam int             FTAG_W        = LA_W - FLASH_WIN_AW
) (
  input  logic [RTAG_W-1:0] addr_tag,
  input  logic              rom_hi_map,
  output logic              hit_ram,
  output logic              hit_flash_lo,
  output logic              hit_flash_hi
);

  localparam logic [RTAG_W-1:0] RAM_TAG = RAM_WIN_BASE[LA_W-1:RAM_WIN_AW];
  localparam logic [FTAG_W-1:0] FHI_TAG = FLASH_HI_BASE[LA_W-1:FLASH_WIN_AW];
  localparam logic [FTAG_W-1:0] FLO_TAG = FLASH_LO_BASE[LA_W-1:FLASH_WIN_AW];

  // the flash slices are coarser than the RAM window: their tag is the top of the RAM tag
  logic [FTAG_W-1:0] ftag;
  assign ftag = addr_tag[RTAG_W-1:RTAG_W-FTAG_W];

  assign hit_ram      = (addr_tag == RAM_TAG);
  assign hit_flash_hi = (ftag == FHI_TAG);

  generate
    if (LO_FLASH_EN) begin : g_lo_flash
      assign hit_flash_lo = (ftag == FLO_TAG) && !rom_hi_map;
    end else begin : g_no_lo_flash
      assign hit_flash_lo = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/xlat_addr_compose.sv
module xlat_addr_compose
  import ram_window_xlat_pkg::*;
#(
  parameter int              LA_W          = 16,
  parameter int              GA_W          = 23,
  parameter int              PG_W          = 8,
  parameter int              RAM_WIN_AW    = 12,
  parameter int              FLASH_WIN_AW  = 14,
  parameter logic [PG_W-1:0] FLASH_LO_PAGE = 8'hFD,
  parameter logic [PG_W-1:0] FLASH_HI_PAGE = 8'hFF,
  localparam int             RAM_PAD_W     = GA_W - PG_W - RAM_WIN_AW,
  localparam int             FL_PAD_W      = GA_W - PG_W - FLASH_WIN_AW,
  localparam int             PL_PAD_W      = GA_W - LA_W
) (
  input  logic [LA_W-1:0] loc_addr,
  input  logic            loc_wr,
  input  logic [PG_W-1:0] page_q,
  input  logic            hit_ram,
  input  logic            hit_flash_lo,
  input  logic            hit_flash_hi,
  output logic [GA_W-1:0] glb_addr,
  output region_e         region,
  output logic            reg_alias_wr
);

  logic [GA_W-1:0] ram_ga;
  logic [GA_W-1:0] flo_ga;
  logic [GA_W-1:0] fhi_ga;
  logic [GA_W-1:0] pl_ga;

  assign ram_ga = {{RAM_PAD_W{1'b0}}, page_q, loc_addr[RAM_WIN_AW-1:0]};
  assign flo_ga = {{FL_PAD_W{1'b1}}, FLASH_LO_PAGE, loc_addr[FLASH_WIN_AW-1:0]};
  assign fhi_ga = {{FL_PAD_W{1'b1}}, FLASH_HI_PAGE, loc_addr[FLASH_WIN_AW-1:0]};
  assign pl_ga  = {{PL_PAD_W{1'b0}}, loc_addr};

  always_comb begin
    glb_addr = pl_ga;
    region   = RGN_PLAIN;
    if (hit_ram) begin
      glb_addr = ram_ga;
      region   = RGN_RAM;
    end else if (hit_flash_hi) begin
      glb_addr = fhi_ga;
      region   = RGN_FLASH;
    end else if (hit_flash_lo) begin
      glb_addr = flo_ga;
      region   = RGN_FLASH;
    end
  end

  // page 0 of RAM shares its global location with the register space
  assign reg_alias_wr = hit_ram && (page_q == '0) && loc_wr;

endmodule

// File: rtl/ram_window_xlat.sv
module ram_window_xlat
  import ram_window_xlat_pkg::*;
#(
  parameter int              LA_W          = 16,
  parameter int              GA_W          = 23,
  parameter int              PG_W          = 8,
  parameter int              RAM_WIN_AW    = 12,
  parameter int              FLASH_WIN_AW  = 14,
  parameter logic [LA_W-1:0] RAM_WIN_BASE  = 16'h1000,
  parameter logic [LA_W-1:0] FLASH_LO_BASE = 16'h4000,
  parameter logic [LA_W-1:0] FLASH_HI_BASE = 16'hC000,
  parameter logic [PG_W-1:0] FLASH_LO_PAGE = 8'hFD,
  parameter logic [PG_W-1:0] FLASH_HI_PAGE = 8'hFF,
  parameter logic [PG_W-1:0] PAGE_RST      = 8'hFD,
  parameter bit              LO_FLASH_EN   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [PG_W-1:0] cfg_wdata,
  output logic [PG_W-1:0] cfg_rdata,
  input  logic            rom_hi_map,
  input  logic [LA_W-1:0] loc_addr,
  input  logic            loc_wr,
  output logic [GA_W-1:0] glb_addr,
  output logic [1:0]      region,
  output logic            reg_alias_wr
);

  localparam int RTAG_W = LA_W - RAM_WIN_AW;

  logic [PG_W-1:0] page_q;
  logic            hit_ram;
  logic            hit_flash_lo;
  logic            hit_flash_hi;
  region_e         region_int;

  xlat_page_reg #(
    .PG_W    (PG_W),
    .RST_VAL (PAGE_RST)
  ) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wdata  (cfg_wdata),
    .page_q (page_q)
  );

  xlat_window_decode #(
    .LA_W          (LA_W),
    .RAM_WIN_AW    (RAM_WIN_AW),
    .FLASH_WIN_AW  (FLASH_WIN_AW),
    .RAM_WIN_BASE  (RAM_WIN_BASE),
    .FLASH_LO_BASE (FLASH_LO_BASE),
    .FLASH_HI_BASE (FLASH_HI_BASE),
    .LO_FLASH_EN   (LO_FLASH_EN)
  ) u_dec (
    .addr_tag     (loc_addr[LA_W-1:LA_W-RTAG_W]),
    .rom_hi_map   (rom_hi_map),
    .hit_ram      (hit_ram),
    .hit_flash_lo (hit_flash_lo),
    .hit_flash_hi (hit_flash_hi)
  );

  xlat_addr_compose #(
    .LA_W          (LA_W),
    .GA_W          (GA_W),
    .PG_W          (PG_W),
    .RAM_WIN_AW    (RAM_WIN_AW),
    .FLASH_WIN_AW  (FLASH_WIN_AW),
    .FLASH_LO_PAGE (FLASH_LO_PAGE),
    .FLASH_HI_PAGE (FLASH_HI_PAGE)
  ) u_cmp (
    .loc_addr     (loc_addr),
    .loc_wr       (loc_wr),
    .page_q       (page_q),
    .hit_ram      (hit_ram),
    .hit_flash_lo (hit_flash_lo),
    .hit_flash_hi (hit_flash_hi),
    .glb_addr     (glb_addr),
    .region       (region_int),
    .reg_alias_wr (reg_alias_wr)
  );

  assign cfg_rdata = page_q;
  assign region    = region_int;

endmodule

// File: rtl/ram_window_xlat_chk.sv
module ram_window_xlat_chk #(
  parameter int              LA_W          = 16,
  parameter int              GA_W          = 23,
  parameter int              PG_W          = 8,
  parameter int              RAM_WIN_AW    = 12,
  parameter logic [PG_W-1:0] FLASH_HI_PAGE = 8'hFF,
  parameter logic [PG_W-1:0] PAGE_RST      = 8'hFD
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [PG_W-1:0] cfg_wdata,
  input logic [PG_W-1:0] cfg_rdata,
  input logic [LA_W-1:0] loc_addr,
  input logic            loc_wr,
  input logic [GA_W-1:0] glb_addr,
  input logic [1:0]      region,
  input logic            reg_alias_wr
);

  // R1: value seen at the first edge out of reset
  p_reset_val_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> cfg_rdata == PAGE_RST);

  // R2: a write lands at the edge, otherwise the index holds
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  p_index_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  // R3: window hit takes page from the index, offset from the local address
  p_ram_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    region == 2'b01 |-> (glb_addr[RAM_WIN_AW+PG_W-1:RAM_WIN_AW] == cfg_rdata) &&
                        (glb_addr[RAM_WIN_AW-1:0] == loc_addr[RAM_WIN_AW-1:0]));

  // R4: top bits cleared on a window hit
  p_ram_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    region == 2'b01 |-> glb_addr[GA_W-1:RAM_WIN_AW+PG_W] == '0);

  // R5: alias flag only for a write through the window at index zero
  p_alias_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_alias_wr |-> (region == 2'b01) && (cfg_rdata == '0) && loc_wr);

  // R8: top slice always goes to the fixed high flash page
  p_flash_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loc_addr[LA_W-1:LA_W-2] == 2'b11 |-> (region == 2'b10) &&
                                         (glb_addr[GA_W-2:GA_W-1-PG_W] == FLASH_HI_PAGE));

  // R9: an unpaged result carries the local address with zero upper bits
  p_plain_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    region == 2'b00 |-> glb_addr[GA_W-1:LA_W] == '0 && glb_addr[LA_W-1:0] == loc_addr);

  // region code never takes the unused value
  p_region_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    region != 2'b11);

endmodule

bind ram_window_xlat ram_window_xlat_chk #(
  .LA_W          (LA_W),
  .GA_W          (GA_W),
  .PG_W          (PG_W),
  .RAM_WIN_AW    (RAM_WIN_AW),
  .FLASH_HI_PAGE (FLASH_HI_PAGE),
  .PAGE_RST      (PAGE_RST)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .loc_addr     (loc_addr),
  .loc_wr       (loc_wr),
  .glb_addr     (glb_addr),
  .region       (region),
  .reg_alias_wr (reg_alias_wr)
);

// File: tb/ram_window_xlat_bench.sv
module ram_window_xlat_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        rom_hi_map;
  logic [15:0] loc_addr;
  logic        loc_wr;
  logic [22:0] glb_addr;
  logic [1:0]  region;
  logic        reg_alias_wr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  ram_window_xlat u_ram_window_xlat (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .rom_hi_map   (rom_hi_map),
    .loc_addr     (loc_addr),
    .loc_wr       (loc_wr),
    .glb_addr     (glb_addr),
    .region       (region),
    .reg_alias_wr (reg_alias_wr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // arithmetic reference model taken from the requirements
  task automatic model(input int a, input int pg, input bit hi, input bit wr,
                       output int ga, output int rg, output bit al, output string req);
    al = 1'b0;
    if (a >= 'h1000 && a < 'h2000) begin
      ga = pg * 'h1000 + (a % 'h1000); rg = 1; al = (pg == 0) && wr; req = "R3/R4/R5";
    end else if (a >= 'hC000) begin
      ga = 'h400000 + 'hFF * 'h4000 + (a % 'h4000); rg = 2; req = "R8";
    end else if (a >= 'h4000 && a < 'h8000 && !hi) begin
      ga = 'h400000 + 'hFD * 'h4000 + (a % 'h4000); rg = 2; req = "R6";
    end else if (a >= 'h4000 && a < 'h8000) begin
      ga = a; rg = 0; req = "R7";
    end else begin
      ga = a; rg = 0; req = "R9";
    end
  endtask

  task automatic probe(input int a, input int pg, input bit hi, input bit wr);
    int ga; int rg; bit al; string req;
    @(posedge clk);
    #2;
    loc_addr = a[15:0]; rom_hi_map = hi; loc_wr = wr;
    #1;
    model(a, pg, hi, wr, ga, rg, al, req);
    check(int'(glb_addr) == ga && int'(region) == rg && reg_alias_wr == al, req,
          int'({reg_alias_wr, region, glb_addr}), int'({al, rg[1:0], ga[22:0]}));
  endtask

  task automatic write_page(input int v);
    @(posedge clk);
    #2;
    cfg_we = 1'b1; cfg_wdata = v[7:0];
    @(posedge clk);
    #2;
    cfg_we = 1'b0;
    check(int'(cfg_rdata) == v, "R2 readback", int'(cfg_rdata), v);
  endtask

  task automatic sweep(input int pg, input bit hi, input int stride);
    for (int a = 0; a < 65536; a += stride) begin
      probe(a, pg, hi, a[0] ^ a[4]);
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
    rom_hi_map = 1'b0; loc_addr = 16'h0000; loc_wr = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    // R1: reset value and its translation
    check(cfg_rdata == 8'hFD, "R1 reset index", int'(cfg_rdata), 'hFD);
    loc_addr = 16'h1234;
    #1;
    check(glb_addr == 23'h0FD234, "R1 reset translation", int'(glb_addr), 'h0FD234);

    // R2: old value stays until the edge, new one applies after it
    @(posedge clk);
    #2;
    cfg_we = 1'b1; cfg_wdata = 8'h3C; loc_addr = 16'h1010;
    #1;
    check(glb_addr == 23'h0FD010, "R2 before edge", int'(glb_addr), 'h0FD010);
    @(posedge clk);
    #2;
    cfg_we = 1'b0;
    check(glb_addr == 23'h03C010, "R2 after edge", int'(glb_addr), 'h03C010);
    cfg_wdata = 8'h55;
    @(posedge clk);
    #2;
    check(cfg_rdata == 8'h3C, "R2 hold without strobe", int'(cfg_rdata), 'h3C);

    // R10: outputs follow inputs inside one cycle
    @(posedge clk);
    #1;
    loc_addr = 16'h1FFF; rom_hi_map = 1'b0;
    #1;
    check(glb_addr == 23'h03CFFF, "R10 first change", int'(glb_addr), 'h03CFFF);
    loc_addr = 16'h4001;
    #1;
    check(glb_addr == 23'h7F4001 && region == 2'b10, "R10 second change", int'(glb_addr), 'h7F4001);
    rom_hi_map = 1'b1;
    #1;
    check(glb_addr == 23'h004001 && region == 2'b00, "R10 map toggle", int'(glb_addr), 'h004001);

    // full sweep with reset-like index, low flash active (R3 R6 R8 R9)
    write_page('hFD);
    sweep('hFD, 1'b0, 1);
    // index zero: alias flag (R5)
    write_page('h00);
    sweep('h00, 1'b0, 4);
    // high map set: middle slice unpaged (R7)
    write_page('hA5);
    sweep('hA5, 1'b1, 4);
    write_page('hFF);
    sweep('hFF, 1'b0, 8);
    // every index value at the window edges (R3 R4 R5)
    for (int p = 0; p < 256; p++) begin
      write_page(p);
      probe('h1000, p, 1'b0, 1'b1);
      probe('h1FFF, p, 1'b1, 1'b1);
      probe('h0FFF, p, 1'b0, 1'b1);
      probe('h2000, p, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule